// File: doc/BRIEF.md
# Buffered Multi-Channel PWM Timer

This block holds five independent down-counting timer channels behind a small memory-mapped register file. Each channel owns a period buffer and a compare buffer. Software writes the buffers, then asks for a manual load, which copies both buffers into the channel's working counter and working compare register. Once started, a channel counts down one step per enabled tick. At terminal count it either reloads itself from the buffers or halts, depending on its reload flag.

Channels 0 to 3 each drive a PWM pin. The raw level is set when the working counter reaches the working compare value. It stays set until the next load, and an optional inversion flips the pin. Channel 4 has no pin and serves only as a timebase through its terminal-count pulse.

All control flags share a single control word. Each channel has a 4-bit group in that word. The groups are not evenly spaced, and the reload flag of channel 4 sits at a different position within its group. Ticks are supplied from outside the block, one enable per channel.

Top module: `pwm_bank_timer`

## Requirements
- R1: After reset every register reads 0, `pwm_out` is 0 and `tc_pulse` is 0.
- R2: Byte addresses are decoded as follows. The control word is at 0x08. The period buffer of channel c is at 0x0C+12*c and its compare buffer at 0x10+12*c. A buffer read returns the stored value zero-extended from 16 bits, and an unmapped address reads 0.
- R3: Control groups are 4 bits wide. Channel 0 uses bits 3:0 and channel c≥1 uses bits starting at 4*(c+1), so bits 7:4 are unused. Within a group, offset 0 is start, offset 1 is manual load, offset 2 is invert and offset 3 is auto-reload. Channel 4 differs: its auto-reload is at offset 2 and it has no invert. The readable mask is therefore 0x007FFF0F, and bits outside it read 0.
- R4: In every cycle in which a channel's manual-load flag is set, its working counter and working compare take the buffer values and counting is suspended.
- R5: A period buffer value of N-1 gives a period of N counted ticks. Each period ends with exactly one single-cycle `tc_pulse`, raised in the cycle after the counter leaves 0.
- R6: With compare value M < N, the raw level is high for M+1 of every N counted ticks, namely while the counter runs from M down to 0.
- R7: When a channel's invert flag is set, its pin carries the complement of the raw level.
- R8: A compare value the counter never reaches, such as 0xFFFF, keeps the raw level low for good. With invert set, the pin is then constantly high.
- R9: A channel steps only on cycles where its start flag and its tick enable are both high.
- R10: While a channel's start flag is clear, its counter, its pin and its terminal pulse stay frozen.
- R11: With auto-reload clear, the channel gives one terminal pulse when its period completes and then stays halted until the next manual load.
- R12: Writing a buffer while a channel is running does not change the period in progress. The new value is used only at the next load or reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, available in the same cycle |
| tick_en | input | 5 | Per-channel count enable |
| pwm_out | output | 4 | PWM pins of channels 0 to 3 |
| tc_pulse | output | 5 | Per-channel terminal-count pulse |

## Verification
Read data is combinational, so it is compared in the same cycle the address is driven, half a clock later. A register write becomes visible at the edge that takes it. A control change reaches a channel one edge later, so a manual load issued by one write has acted by the time the following write lands. Each channel output moves one edge after the tick that causes it. For example, a one-shot channel with period buffer 19 raises its terminal pulse 20 edges after the start write, and the bench counts edges from that write and checks the 21st sample. Duty and pulse rates are measured over a 200-cycle window that is a whole number of periods for every channel, so the counts do not depend on the phase at which the window opens.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    localparam int CTRL_ADDR   = 8;
    localparam int CNT_BASE    = 12;
    localparam int CMP_BASE    = 16;
    localparam int CH_STRIDE   = 12;
    localparam int MOVED_ARL   = 4;

    // first bit of a channel's control group; one group is skipped after channel 0
    function automatic int grp_lsb(int c);
        return (c == 0) ? 0 : 4 * (c + 1);
    endfunction

    function automatic int arl_bit(int c);
        return (c == MOVED_ARL) ? grp_lsb(c) + 2 : grp_lsb(c) + 3;
    endfunction

    function automatic int cnt_addr(int c);
        return CNT_BASE + CH_STRIDE * c;
    endfunction

    function automatic int cmp_addr(int c);
        return CMP_BASE + CH_STRIDE * c;
    endfunction

    function automatic logic [63:0] ctrl_mask(int nch, int nout);
        logic [63:0] m;
        m = '0;
        for (int c = 0; c < nch; c++) begin
            m[grp_lsb(c)]     = 1'b1;
            m[grp_lsb(c) + 1] = 1'b1;
            m[arl_bit(c)]     = 1'b1;
            if (c < nout) m[grp_lsb(c) + 2] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs #(
    parameter int NCH  = 5,
    parameter int NOUT = 4,
    parameter int CW   = 16,
    parameter int AW   = 8,
    parameter int DW   = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic [AW-1:0]            bus_addr,
    input  logic [DW-1:0]            bus_wdata,
    output logic [DW-1:0]            bus_rdata,
    output logic [NCH-1:0]           start_o,
    output logic [NCH-1:0]           mupd_o,
    output logic [NCH-1:0]           arl_o,
    output logic [NOUT-1:0]          inv_o,
    output logic [NCH-1:0][CW-1:0]   cnt_buf_o,
    output logic [NCH-1:0][CW-1:0]   cmp_buf_o
);
    import pwm_bank_pkg::*;

    localparam logic [DW-1:0] MASK = DW'(ctrl_mask(NCH, NOUT));

    typedef struct packed {
        logic [DW-1:0]          ctrl;
        logic [NCH-1:0][CW-1:0] cnt;
        logic [NCH-1:0][CW-1:0] cmp;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (bus_wr) begin
            if (bus_addr == AW'(CTRL_ADDR)) d.ctrl = bus_wdata & MASK;
            for (int c = 0; c < NCH; c++) begin
                if (bus_addr == AW'(cnt_addr(c))) d.cnt[c] = bus_wdata[CW-1:0];
                if (bus_addr == AW'(cmp_addr(c))) d.cmp[c] = bus_wdata[CW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(CTRL_ADDR)) bus_rdata = q.ctrl;
        for (int c = 0; c < NCH; c++) begin
            if (bus_addr == AW'(cnt_addr(c))) bus_rdata = DW'(q.cnt[c]);
            if (bus_addr == AW'(cmp_addr(c))) bus_rdata = DW'(q.cmp[c]);
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_fld
        localparam int B  = grp_lsb(c);
        localparam int AP = arl_bit(c);
        assign start_o[c]   = q.ctrl[B];
        assign mupd_o[c]    = q.ctrl[B + 1];
        assign arl_o[c]     = q.ctrl[AP];
        assign cnt_buf_o[c] = q.cnt[c];
        assign cmp_buf_o[c] = q.cmp[c];
    end

    for (genvar c = 0; c < NOUT; c++) begin : g_inv
        localparam int B = grp_lsb(c);
        assign inv_o[c] = q.ctrl[B + 2];
    end

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mupd,
    input  logic          arl,
    input  logic          tick,
    input  logic [CW-1:0] cnt_buf,
    input  logic [CW-1:0] cmp_buf,
    output logic [CW-1:0] cnt_work,
    output logic [CW-1:0] cmp_work,
    output logic          raw,
    output logic          tc
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] cmp;
        logic          raw;
        logic          halt;
        logic          tc;
    } chan_t;

    chan_t q, d;
    logic  step;
    logic [CW-1:0] dec;

    assign step = start && tick && !q.halt;
    assign dec  = q.cnt - CW'(1);

    always_comb begin
        d    = q;
        d.tc = 1'b0;
        if (mupd) begin
            d.cnt  = cnt_buf;
            d.cmp  = cmp_buf;
            d.raw  = (cnt_buf == cmp_buf);
            d.halt = 1'b0;
        end else if (step) begin
            if (q.cnt == '0) begin
                d.tc = 1'b1;
                if (arl) begin
                    d.cnt = cnt_buf;
                    d.cmp = cmp_buf;
                    d.raw = (cnt_buf == cmp_buf);
                end else begin
                    d.halt = 1'b1;
                end
            end else begin
                d.cnt = dec;
                if (dec == q.cmp) d.raw = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt_work = q.cnt;
    assign cmp_work = q.cmp;
    assign raw      = q.raw;
    assign tc       = q.tc;

endmodule

// File: rtl/pwm_bank_timer.sv
module pwm_bank_timer #(
    parameter int NCH  = 5,
    parameter int NOUT = 4,
    parameter int CW   = 16,
    parameter int AW   = 8,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NCH-1:0]  tick_en,
    output logic [NOUT-1:0] pwm_out,
    output logic [NCH-1:0]  tc_pulse
);
    logic [NCH-1:0]          start_w;
    logic [NCH-1:0]          mupd_w;
    logic [NCH-1:0]          arl_w;
    logic [NOUT-1:0]         inv_w;
    logic [NCH-1:0][CW-1:0]  cnt_buf_w;
    logic [NCH-1:0][CW-1:0]  cmp_buf_w;
    logic [NCH-1:0][CW-1:0]  cnt_work_w;
    logic [NCH-1:0][CW-1:0]  cmp_work_w;
    logic [NCH-1:0]          raw_w;

    pwm_bank_regs #(
        .NCH(NCH), .NOUT(NOUT), .CW(CW), .AW(AW), .DW(DW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .start_o   (start_w),
        .mupd_o    (mupd_w),
        .arl_o     (arl_w),
        .inv_o     (inv_w),
        .cnt_buf_o (cnt_buf_w),
        .cmp_buf_o (cmp_buf_w)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pwm_bank_chan #(.CW(CW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (start_w[c]),
            .mupd     (mupd_w[c]),
            .arl      (arl_w[c]),
            .tick     (tick_en[c]),
            .cnt_buf  (cnt_buf_w[c]),
            .cmp_buf  (cmp_buf_w[c]),
            .cnt_work (cnt_work_w[c]),
            .cmp_work (cmp_work_w[c]),
            .raw      (raw_w[c]),
            .tc       (tc_pulse[c])
        );
    end

    for (genvar c = 0; c < NOUT; c++) begin : g_pin
        assign pwm_out[c] = inv_w[c] ? ~raw_w[c] : raw_w[c];
    end

endmodule

// File: rtl/pwm_bank_timer_chk.sv
module pwm_bank_timer_chk #(
    parameter int NCH = 5,
    parameter int CW  = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NCH-1:0]         start,
    input logic [NCH-1:0]         mupd,
    input logic [NCH-1:0][CW-1:0] cnt_buf,
    input logic [NCH-1:0][CW-1:0] cmp_buf,
    input logic [NCH-1:0][CW-1:0] cnt_work,
    input logic [NCH-1:0][CW-1:0] cmp_work,
    input logic [NCH-1:0]         raw,
    input logic [NCH-1:0]         tc
);
    for (genvar c = 0; c < NCH; c++) begin : g_c
        // R4
        mupd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mupd[c] |=> (cnt_work[c] == $past(cnt_buf[c])) && (cmp_work[c] == $past(cmp_buf[c])));

        // R10
        freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!start[c] && !mupd[c]) |=> $stable(cnt_work[c]) && $stable(raw[c]) && !tc[c]);

        // R5
        tc_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tc[c] |-> ($past(cnt_work[c]) == '0));

        // R12
        cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !mupd[c] |=> ($stable(cmp_work[c]) || tc[c]));

        // R6
        raw_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(raw[c]) |-> (cnt_work[c] == cmp_work[c]));
    end
endmodule

bind pwm_bank_timer pwm_bank_timer_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_w),
    .mupd     (mupd_w),
    .cnt_buf  (cnt_buf_w),
    .cmp_buf  (cmp_buf_w),
    .cnt_work (cnt_work_w),
    .cmp_work (cmp_work_w),
    .raw      (raw_w),
    .tc       (tc_pulse)
);

// File: tb/pwm_bank_timer_bench.sv
module pwm_bank_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  tick_rest = 5'h1F;
    logic        tick_tog = 1'b0;
    logic [4:0]  tick_en;
    logic [3:0]  pwm_out;
    logic [4:0]  tc_pulse;

    assign tick_en = {tick_rest[4], tick_rest[3] & tick_tog, tick_rest[2:0]};

    always #5 clk = ~clk;

    pwm_bank_timer u_pwm_bank_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
        .pwm_out(pwm_out), .tc_pulse(tc_pulse)
    );

    typedef struct {
        string       req;
        int          sel;
        logic [31:0] exp;
        logic [31:0] act;
    } item_t;

    item_t sb_q[$];
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    int    hi_cnt[5];
    int    tc_cnt[5];

    task automatic push(string req, int sel, logic [31:0] exp, logic [31:0] act);
        item_t it;
        it.req = req; it.sel = sel; it.exp = exp; it.act = act;
        sb_q.push_back(it);
    endtask

    // monitor: compares queued expectations at each falling edge
    initial forever begin
        @(negedge clk);
        while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] a;
            it = sb_q.pop_front();
            case (it.sel)
                0: a = bus_rdata;
                1: a = {28'h0, pwm_out};
                2: a = {27'h0, tc_pulse};
                default: a = it.act;
            endcase
            n_vec++;
            if (a !== it.exp) begin
                n_bad++;
                $display("FAIL %s: got %h expected %h", it.req, a, it.exp);
            end
        end
    end

    initial forever begin
        @(posedge clk); #1;
        tick_tog = ~tick_tog;
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
        @(posedge clk); #1;
        bus_addr = a;
        push(req, 0, exp, '0);
    endtask

    task automatic measure(int n);
        for (int c = 0; c < 5; c++) begin hi_cnt[c] = 0; tc_cnt[c] = 0; end
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            for (int c = 0; c < 4; c++) if (pwm_out[c]) hi_cnt[c]++;
            for (int c = 0; c < 5; c++) if (tc_pulse[c]) tc_cnt[c]++;
        end
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int first_tc;
        int n_tc4;
        int chg0, chg1, tcs;
        logic p0, p1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(posedge clk); #1;
        push("R1 pins", 1, 32'h0, '0);
        push("R1 tc", 2, 32'h0, '0);
        rd_chk("R1 ctrl", 8'h08, 32'h0);
        rd_chk("R1 cnt0", 8'h0C, 32'h0);

        // R2 address map and readback
        wr(8'h24, 32'h0000_1234);
        wr(8'h40, 32'hFFFF_BEEF);
        rd_chk("R2 cnt2", 8'h24, 32'h0000_1234);
        rd_chk("R2 cmp4", 8'h40, 32'h0000_BEEF);
        rd_chk("R2 unmapped", 8'h04, 32'h0);

        // configure all channels
        wr(8'h0C, 9);  wr(8'h10, 3);
        wr(8'h18, 9);  wr(8'h1C, 3);
        wr(8'h24, 9);  wr(8'h28, 32'hFFFF);
        wr(8'h30, 3);  wr(8'h34, 1);
        wr(8'h3C, 19); wr(8'h40, 5);
        wr(8'h08, 32'h0022_2202);   // manual load, all channels
        wr(8'h08, 32'h0009_DD09);   // start ch0..3 with reload, invert ch1/ch2
        repeat (30) @(posedge clk);
        measure(200);
        push("R6 ch0 high ticks", 3, 80, hi_cnt[0]);
        push("R5 ch0 pulses", 3, 20, tc_cnt[0]);
        push("R7 ch1 inverted high", 3, 120, hi_cnt[1]);
        push("R8 ch2 constant high", 3, 200, hi_cnt[2]);
        push("R5 ch2 pulses", 3, 20, tc_cnt[2]);
        push("R9 ch3 half-rate high", 3, 100, hi_cnt[3]);
        push("R9 ch3 half-rate pulses", 3, 25, tc_cnt[3]);
        push("R10 ch4 idle pulses", 3, 0, tc_cnt[4]);

        // R4 R11 R12 one-shot on ch4 with buffer rewrite mid-period
        wr(8'h08, 32'h0029_DD09);
        wr(8'h08, 32'h0019_DD09);
        first_tc = 0; n_tc4 = 0;
        fork
            begin
                repeat (5) @(posedge clk);
                wr(8'h3C, 2);
            end
            begin
                for (int k = 1; k <= 60; k++) begin
                    @(negedge clk);
                    if (tc_pulse[4]) begin
                        n_tc4++;
                        if (first_tc == 0) first_tc = k;
                    end
                end
            end
        join
        push("R4 R12 ch4 terminal sample", 3, 21, first_tc);
        push("R11 ch4 single pulse", 3, 1, n_tc4);
        rd_chk("R2 cnt4 readback", 8'h3C, 32'h2);

        // R10 freeze ch0, R9 tick gate ch1
        wr(8'h08, 32'h0009_DD08);
        tick_rest[1] = 1'b0;
        @(negedge clk);
        p0 = pwm_out[0]; p1 = pwm_out[1];
        chg0 = 0; chg1 = 0; tcs = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (pwm_out[0] != p0) chg0++;
            if (pwm_out[1] != p1) chg1++;
            if (tc_pulse[0] || tc_pulse[1]) tcs++;
        end
        push("R10 ch0 frozen pin", 3, 0, chg0);
        push("R9 ch1 no tick pin", 3, 0, chg1);
        push("R10 frozen pulses", 3, 0, tcs);
        tick_rest[1] = 1'b1;

        // R3 control layout mask
        wr(8'h08, 32'hFFFF_FFFF);
        rd_chk("R3 ctrl mask", 8'h08, 32'h007F_FF0F);
        wr(8'h08, 32'h0000_0000);
        rd_chk("R3 ctrl cleared", 8'h08, 32'h0);

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule